// File: doc/BRIEF.md
# Edge Interrupt and Wake Controller

This block watches a bank of already synchronized GPIO inputs and turns their transitions into interrupt and wakeup events. Every clock it compares the present sample of each pin with the sample from the previous clock. This gives a rising-edge and a falling-edge pulse per pin. Two pairs of per-pin enable masks select which of those pulses count. One pair feeds the normal interrupt path. The other pair feeds the wakeup path only. Only edges are detected; a pin held at a steady level never raises anything.

Enabled normal edges set sticky pending bits. Software clears a pending bit by writing a one to it. The combined interrupt line stays high while any pending bit remains, so a handler can keep servicing pins until the status reads zero. A read-only register gives the lowest-numbered pending pin and a valid flag, which saves the handler a bit scan. Enabled wake edges drive the wakeup line in the same cycle and also set a sticky wake flag, which is cleared by a write of one. All registers sit behind a simple single-cycle write port with a combinational read port.

Top module: `edge_irq_wake_ctrl`

## Requirements
- R1: After reset every mask, every pending bit and the wake flag read as zero, and both irq_out and wake_out are low.
- R2: A 0-to-1 change on pin i while rise-mask bit i (address 0) is set makes status bit i (address 4) read 1 on the following clock; with the bit clear, nothing is recorded.
- R3: A 1-to-0 change on pin i while fall-mask bit i (address 1) is set records status bit i; when both rise and fall masks are set, either direction is recorded.
- R4: A pin held at a constant level records nothing, even when its masks are enabled.
- R5: A write to address 4 clears exactly the status bits written as 1; bits written as 0 are unchanged.
- R6: If an enabled edge and a clear of the same status bit occur in the same cycle, the bit stays pending.
- R7: Clearing a mask bit does not remove a status bit that is already pending.
- R8: irq_out is high exactly while at least one status bit is set.
- R9: wake_out is high in the same cycle as an edge that is enabled by rise-wake mask (address 2) or fall-wake mask (address 3). Wake masks never set status bits, and normal masks never drive wake_out.
- R10: Any cycle with wake_out high sets the wake flag, which reads at address 6 bit 0. Writing 1 to that bit clears the flag, unless a wake edge occurs in the same cycle.
- R11: Address 5 reads the index of the lowest-numbered pending pin in bits 4:0, with bit 31 set when any pin is pending. It reads all zero when nothing is pending.
- R12: Each of the four mask registers reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 32 | Synchronized pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_out | output | 1 | Combined interrupt to the parent controller |
| wake_out | output | 1 | Wakeup event line |

## Verification
Every pin is swept through all four rise/fall mask combinations and given a rising and then a falling transition. This separates per-edge masking, wrong-pin mapping and the index encoder at each position. Steady-level holds and mask removal after capture show that recording is edge-only and that pending bits are sticky. Clears are issued both alone and in the same cycle as a new edge, which tells apart a correct edge-wins merge from a plain overwrite. Wake-only and interrupt-only mask setups show that the two paths are isolated from each other.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_RISE  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_FALL  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RWAKE = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_FWAKE = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_FIRST = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_WAKE  = 3'd6;
endpackage

// File: rtl/edge_detect.sv
module edge_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins,
  output logic [NPINS-1:0] rise,
  output logic [NPINS-1:0] fall
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pins;
  end

  assign rise = pins & ~prev_q;
  assign fall = ~pins & prev_q;
endmodule

// File: rtl/pend_status.sv
module pend_status #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] hit,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] status
);
  // new edges take priority over a clear in the same cycle
  function automatic logic [NPINS-1:0] merge(input logic [NPINS-1:0] cur,
                                             input logic [NPINS-1:0] h,
                                             input logic [NPINS-1:0] c);
    return (cur & ~c) | h;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= merge(status, hit, clr);
  end
endmodule

// File: rtl/lowest_pending.sv
module lowest_pending #(
  parameter int NPINS = 32,
  localparam int IW = $clog2(NPINS)
) (
  input  logic [NPINS-1:0] vec,
  output logic [IW-1:0]    idx,
  output logic             valid
);
  function automatic logic [IW-1:0] first_set(input logic [NPINS-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int k = NPINS - 1; k >= 0; k--)
      if (v[k]) r = IW'(k);
    return r;
  endfunction

  assign idx   = first_set(vec);
  assign valid = |vec;
endmodule

// File: rtl/edge_irq_wake_ctrl.sv
module edge_irq_wake_ctrl
  import edge_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  reg_rdata,
  output logic              irq_out,
  output logic              wake_out
);
  localparam int IW = $clog2(NPINS);
  localparam int PADW = NPINS - 1 - IW;

  logic [NPINS-1:0] rise, fall;
  logic [NPINS-1:0] rise_m, fall_m, rwake_m, fwake_m;
  logic [NPINS-1:0] hit_vec, wake_vec, clr_vec, status_q;
  logic [IW-1:0]    first_idx;
  logic             first_valid;
  logic             wake_flag_q, wake_clr;

  edge_detect #(.NPINS(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .pins(pin_in), .rise(rise), .fall(fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_m  <= '0;
      fall_m  <= '0;
      rwake_m <= '0;
      fwake_m <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        ADDR_RISE:  rise_m  <= reg_wdata;
        ADDR_FALL:  fall_m  <= reg_wdata;
        ADDR_RWAKE: rwake_m <= reg_wdata;
        ADDR_FWAKE: fwake_m <= reg_wdata;
        default: ;
      endcase
    end
  end

  assign hit_vec  = (rise & rise_m) | (fall & fall_m);
  assign wake_vec = (rise & rwake_m) | (fall & fwake_m);
  assign clr_vec  = (reg_we && reg_addr == ADDR_STAT) ? reg_wdata : '0;
  assign wake_clr = reg_we && reg_addr == ADDR_WAKE && reg_wdata[0];

  pend_status #(.NPINS(NPINS)) u_pend (
    .clk(clk), .rst_n(rst_n), .hit(hit_vec), .clr(clr_vec), .status(status_q));

  lowest_pending #(.NPINS(NPINS)) u_first (
    .vec(status_q), .idx(first_idx), .valid(first_valid));

  assign wake_out = |wake_vec;
  assign irq_out  = |status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wake_flag_q <= 1'b0;
    else if (wake_out) wake_flag_q <= 1'b1;
    else if (wake_clr) wake_flag_q <= 1'b0;
  end

  always_comb begin
    case (reg_addr)
      ADDR_RISE:  reg_rdata = rise_m;
      ADDR_FALL:  reg_rdata = fall_m;
      ADDR_RWAKE: reg_rdata = rwake_m;
      ADDR_FWAKE: reg_rdata = fwake_m;
      ADDR_STAT:  reg_rdata = status_q;
      ADDR_FIRST: reg_rdata = {first_valid, {PADW{1'b0}}, first_idx};
      ADDR_WAKE:  reg_rdata = {{(NPINS-1){1'b0}}, wake_flag_q};
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/edge_irq_wake_ctrl_chk.sv
module edge_irq_wake_ctrl_chk #(
  parameter int NPINS = 32,
  localparam int IW = $clog2(NPINS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] hit_vec,
  input logic [NPINS-1:0] clr_vec,
  input logic [NPINS-1:0] status_q,
  input logic             wake_out,
  input logic             wake_flag_q,
  input logic             irq_out,
  input logic [IW-1:0]    first_idx,
  input logic             first_valid
);
  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec == '0) |=> ((status_q & ~$past(status_q)) == '0)); // R2
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec != '0) && (hit_vec == '0)) |=> ((status_q & $past(clr_vec)) == '0)); // R5
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |=> ((status_q & $past(hit_vec)) == $past(hit_vec))); // R6
  AST_IRQ_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |=> irq_out); // R8
  AST_WAKE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wake_out |=> wake_flag_q); // R10
  AST_FIRST_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    first_valid |-> status_q[first_idx]); // R11
endmodule

bind edge_irq_wake_ctrl edge_irq_wake_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .clr_vec(clr_vec),
  .status_q(status_q), .wake_out(wake_out), .wake_flag_q(wake_flag_q),
  .irq_out(irq_out), .first_idx(first_idx), .first_valid(first_valid));

// File: tb/test_edge_irq_wake_ctrl.sv
module test_edge_irq_wake_ctrl;
  localparam int N = 32;
  logic          clk = 0;
  logic          rst_n = 0;
  logic [N-1:0]  pin_in = '0;
  logic          reg_we = 0;
  logic [2:0]    reg_addr = '0;
  logic [N-1:0]  reg_wdata = '0;
  logic [N-1:0]  reg_rdata;
  logic          irq_out, wake_out;
  int checks = 0, fails = 0;
  logic wake_seen;
  logic [N-1:0] rv;
  bit done = 0;

  always #10 clk = ~clk;

  edge_irq_wake_ctrl #(.NPINS(N)) i_edge_irq_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .wake_out(wake_out));

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic drive(input logic [N-1:0] v);
    @(negedge clk); pin_in = v; #1; wake_seen = wake_out;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), rv); chk("R1", rv, '0);
    end
    chk("R1", {31'b0, irq_out}, '0);
    chk("R1", {31'b0, wake_out}, '0);

    // R12 mask readback
    for (int a = 0; a < 4; a++) begin
      wr(3'(a), 32'hA5C3_0F1E ^ (32'h1111_1111 << a));
      rd(3'(a), rv); chk("R12", rv, 32'hA5C3_0F1E ^ (32'h1111_1111 << a));
      wr(3'(a), '0);
    end

    // R2 R3 R8 R11 sweep over pins and mask combinations
    for (int i = 0; i < N; i++) begin
      for (int c = 0; c < 4; c++) begin
        logic [N-1:0] b;
        b = N'(1) << i;
        wr(3'd0, c[0] ? b : '0);
        wr(3'd1, c[1] ? b : '0);
        drive(b);
        rd(3'd4, rv); chk("R2", rv, c[0] ? b : '0);
        chk("R8", {31'b0, irq_out}, {31'b0, c[0]});
        rd(3'd5, rv); chk("R11", rv, c[0] ? ({1'b1, 31'b0} | N'(i)) : '0);
        wr(3'd4, '1);
        drive('0);
        rd(3'd4, rv); chk("R3", rv, c[1] ? b : '0);
        wr(3'd4, '1);
      end
    end

    // R4 steady level records nothing
    wr(3'd0, '1); wr(3'd1, '1);
    drive(32'h0000_00F0);
    wr(3'd4, '1);
    repeat (4) @(negedge clk);
    rd(3'd4, rv); chk("R4", rv, '0);
    chk("R8", {31'b0, irq_out}, '0);

    // R5 write-one-to-clear, zeros leave bits
    drive(32'h0000_0000);   // falls on 7:4
    rd(3'd4, rv); chk("R3", rv, 32'h0000_00F0);
    wr(3'd4, 32'h0000_0030);
    rd(3'd4, rv); chk("R5", rv, 32'h0000_00C0);
    rd(3'd5, rv); chk("R11", rv, 32'h8000_0006);

    // R7 removing masks keeps pending
    wr(3'd0, '0); wr(3'd1, '0);
    rd(3'd4, rv); chk("R7", rv, 32'h0000_00C0);
    wr(3'd4, '1);

    // R11 lowest of several
    wr(3'd0, '1);
    drive(32'h0000_1020);
    rd(3'd5, rv); chk("R11", rv, 32'h8000_0005);
    wr(3'd4, 32'h0000_0020);
    rd(3'd5, rv); chk("R11", rv, 32'h8000_000C);
    wr(3'd4, '1);
    wr(3'd1, '1);

    // R6 edge and clear of the same bit together
    drive(32'h0000_1028);   // rise on bit 3
    rd(3'd4, rv); chk("R2", rv, 32'h0000_0008);
    @(negedge clk);
    pin_in = 32'h0000_1020; // fall on bit 3
    reg_we = 1; reg_addr = 3'd4; reg_wdata = 32'h0000_0008;
    @(negedge clk); reg_we = 0;
    rd(3'd4, rv); chk("R6", rv, 32'h0000_0008);
    wr(3'd4, '1);
    drive('0);
    wr(3'd4, '1);

    // R9 normal masks do not drive wake
    drive(32'h0000_0100);
    chk("R9", {31'b0, wake_seen}, '0);
    rd(3'd6, rv); chk("R10", rv, '0);
    wr(3'd0, '0); wr(3'd1, '0); wr(3'd4, '1);

    // R9 R10 wake masks only
    wr(3'd3, 32'h0000_0100);
    drive('0);
    chk("R9", {31'b0, wake_seen}, 32'd1);
    rd(3'd4, rv); chk("R9", rv, '0);
    rd(3'd6, rv); chk("R10", rv, 32'd1);
    chk("R9", {31'b0, wake_out}, '0);
    wr(3'd6, 32'd0);
    rd(3'd6, rv); chk("R10", rv, 32'd1);
    wr(3'd6, 32'd1);
    rd(3'd6, rv); chk("R10", rv, '0);
    wr(3'd2, 32'h0000_0002);
    drive(32'h0000_0001);   // rise on bit 0 not enabled for wake
    chk("R9", {31'b0, wake_seen}, '0);
    drive(32'h0000_0003);
    chk("R9", {31'b0, wake_seen}, 32'd1);
    rd(3'd6, rv); chk("R10", rv, 32'd1);

    finish_run();
  end
endmodule